// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block turns the two sampled lines of a low-speed USB link into a stream of bytes in a local buffer. It runs from a clock at eight times the bit rate. The two line inputs pass through a two-flop synchroniser. The block is armed by a one-cycle start pulse and then hunts for the sync field. It locks its bit phase to a J-to-K transition and samples each bit about half a bit after that transition. It undoes NRZI coding, drops stuffed bits and assembles bytes LSB first.

Each completed byte is written through a plain write port: a strobe, an address and the data. The first byte of a packet goes to address 0. When the end-of-packet state appears, the block pulses done and presents the number of complete bytes. A buffer overrun and a missing sync each end reception with their own one-cycle error pulse. The block does not interpret the packet contents.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, and whenever no start pulse has armed it, `busy`, `wr_en`, `done`, `err_overflow` and `err_sync` are all low, and line activity causes no writes.
- R2: The end of sync is found only when a K state detected one bit after a J-to-K transition is still K. A single K followed by J sends the receiver back to hunting for the next transition. Here J is dp=0,dm=1, K is dp=1,dm=0, and SE0 is both low.
- R3: NRZI decoding yields a 1 when the `dm` level is unchanged from the previous bit and a 0 when it changed. The last sync bit, which is K, is the reference level.
- R4: A bit that follows six consecutive decoded 1s is discarded and the run count restarts. The trailing 1 of the sync field counts as the first 1 of a run.
- R5: Bytes are assembled LSB first and written with one-cycle `wr_en` strobes to addresses 0, 1, 2, ... in order of arrival.
- R6: SE0 seen in bit slot 1 to 7 of a byte ends the packet. `done` then pulses for one cycle with `byte_count` equal to the number of complete bytes, and any partial byte is discarded.
- R7: SE0 seen in bit slot 0 of a byte does not end the packet. It is decoded by its `dm` level like any other bit.
- R8: A byte completed when DEPTH bytes have already been written is not written. Instead `err_overflow` pulses for one cycle, the block returns to idle and no `done` follows.
- R9: If the sync end is not found within SYNC_TIMEOUT cycles of hunting after start, `err_sync` pulses for one cycle and the block returns to idle.
- R10: At most one of `done`, `err_overflow` and `err_sync` is high in any cycle, and each packet produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms the receiver |
| dp | input | 1 | D+ line sample, asynchronous |
| dm | input | 1 | D- line sample, asynchronous |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | 8 | Received byte |
| done | output | 1 | One-cycle end-of-packet pulse |
| byte_count | output | CW | Complete bytes in the packet, valid with done |
| err_overflow | output | 1 | One-cycle buffer overrun pulse |
| err_sync | output | 1 | One-cycle sync timeout pulse |
| busy | output | 1 | Receiver armed or receiving |

## Verification
The bench puts single K states ahead of the real sync. A receiver that took the first K as the sync end would shift every byte. Runs of 0xFF test stuffing, where a missing discard would corrupt every byte after the sixth 1. One packet carries an SE0 in slot 0 of a middle byte. A receiver that ended on it would report one byte instead of three. Packets whose end arrives one bit and seven bits into a byte must report only the complete bytes. A packet one byte longer than the buffer must give an overflow with no write beyond the last address and no done. A quiet line after start must give the sync error near SYNC_TIMEOUT cycles.

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int OVS          = 8,
  parameter int DEPTH        = 16,
  parameter int SYNC_TIMEOUT = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dp,
  input  logic          dm,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic [CW-1:0] byte_count,
  output logic          err_overflow,
  output logic          err_sync,
  output logic          busy
);
  localparam int HALF = OVS / 2;
  localparam int PW   = $clog2(OVS + HALF + 1);
  localparam int TW   = $clog2(SYNC_TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_CHECK, S_RX} state_t;
  state_t state;

  logic          dp_m, dp_s, dm_m, dm_s, prev_j, last_dm;
  logic [PW-1:0] ph;
  logic [TW-1:0] tcnt;
  logic [2:0]    bitpos, ones;
  logic [7:0]    shreg;
  logic [CW-1:0] cnt;

  wire line_k = dp_s & ~dm_s;
  wire line_j = ~dp_s & dm_s;
  wire se0    = ~dp_s & ~dm_s;
  wire rx_bit = (dm_s == last_dm);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dp_m, dp_s, dm_m, dm_s} <= 4'b0011;
      prev_j <= 1'b1;
      state <= S_IDLE;
      ph <= '0; tcnt <= '0; bitpos <= '0; ones <= '0;
      shreg <= '0; cnt <= '0; last_dm <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      done <= 1'b0; byte_count <= '0;
      err_overflow <= 1'b0; err_sync <= 1'b0;
    end else begin
      dp_m <= dp; dp_s <= dp_m;
      dm_m <= dm; dm_s <= dm_m;
      prev_j <= line_j;
      wr_en <= 1'b0; done <= 1'b0;
      err_overflow <= 1'b0; err_sync <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_HUNT;
          tcnt <= '0;
        end
        S_HUNT: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt >= TW'(SYNC_TIMEOUT - 1)) begin
            err_sync <= 1'b1;
            state <= S_IDLE;
          end else if (line_k && prev_j) begin
            state <= S_CHECK;
            ph <= PW'(1);
          end
        end
        S_CHECK: begin
          ph <= ph + 1'b1;
          if (ph == PW'(OVS + HALF)) begin
            if (line_k) begin
              state <= S_RX;
              ph <= PW'(1);
              bitpos <= '0;
              ones <= 3'd1;
              cnt <= '0;
              last_dm <= 1'b0;
            end else begin
              state <= S_HUNT;
            end
          end
        end
        S_RX: begin
          ph <= ph + 1'b1;
          if (ph == PW'(OVS)) begin
            ph <= PW'(1);
            if (se0 && bitpos != 3'd0) begin
              done <= 1'b1;
              byte_count <= cnt;
              state <= S_IDLE;
            end else begin
              last_dm <= dm_s;
              if (ones == 3'd6) begin
                ones <= '0;
              end else begin
                ones <= rx_bit ? ones + 1'b1 : 3'd0;
                shreg <= {rx_bit, shreg[7:1]};
                bitpos <= bitpos + 1'b1;
                if (bitpos == 3'd7) begin
                  if (cnt == CW'(DEPTH)) begin
                    err_overflow <= 1'b1;
                    state <= S_IDLE;
                  end else begin
                    wr_en <= 1'b1;
                    wr_addr <= cnt[AW-1:0];
                    wr_data <= {rx_bit, shreg[7:1]};
                    cnt <= cnt + 1'b1;
                  end
                end
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> byte_count <= CW'(DEPTH));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> !wr_en && !busy);
  assert_sync_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sync |-> !busy);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_overflow, err_sync}));
endmodule

// File: tb/test_usb_ls_rx.sv
module test_usb_ls_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 8, DEPTH = 16, TMO = 256;
  localparam int AW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dp = 1'b0, dm = 1'b1;
  logic wr_en, done, err_overflow, err_sync, busy;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [CW-1:0] byte_count;

  usb_ls_rx #(.OVS(OVS), .DEPTH(DEPTH), .SYNC_TIMEOUT(TMO)) i_usb_ls_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .dp(dp), .dm(dm),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .byte_count(byte_count), .err_overflow(err_overflow),
    .err_sync(err_sync), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  logic [1:0] lq[$];
  logic [7:0] pkt[$];
  logic [7:0] cap[0:63];
  int ncap, ndone, nov, nsync, last_count, addr_err;
  logic [1:0] cur;
  int run;

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (int'(wr_addr) != ncap) addr_err++;
      if (ncap < 64) cap[ncap] = wr_data;
      ncap++;
    end
    if (done) begin ndone++; last_count = int'(byte_count); end
    if (err_overflow) nov++;
    if (err_sync) nsync++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_obs;
    ncap = 0; ndone = 0; nov = 0; nsync = 0; last_count = -1; addr_err = 0;
  endtask

  task automatic put(input bit b, input bit se0_here);
    if (!b) cur = (cur == LJ) ? LK : LJ;
    if (se0_here && cur == LK) lq.push_back(LSE0); else lq.push_back(cur);
    if (b) begin
      run++;
      if (run == 6) begin
        cur = (cur == LJ) ? LK : LJ;
        lq.push_back(cur);
        run = 0;
      end
    end else run = 0;
  endtask

  task automatic build(input bit noise, input int extra, input int glitch_byte);
    lq.delete();
    cur = LJ; run = 0;
    lq.push_back(LJ);
    if (noise) begin
      lq.push_back(LK); lq.push_back(LJ); lq.push_back(LJ);
      lq.push_back(LK); lq.push_back(LJ);
    end
    for (int i = 0; i < 8; i++) put(i == 7, 1'b0);
    for (int n = 0; n < pkt.size(); n++)
      for (int i = 0; i < 8; i++) put(pkt[n][i], (n == glitch_byte) && (i == 0));
    for (int i = 0; i < extra; i++) put(1'b1, 1'b0);
    lq.push_back(LSE0); lq.push_back(LSE0); lq.push_back(LJ); lq.push_back(LJ);
  endtask

  task automatic send;
    foreach (lq[i]) begin
      {dp, dm} = lq[i];
      repeat (OVS) @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic arm_and_send;
    clear_obs();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    send();
  endtask

  task automatic check_packet(input string req, input int exp_count);
    chk(ndone == 1, {req, " R10 done pulses"}, ndone, 1);
    chk(last_count == exp_count, {req, " R6 byte_count"}, last_count, exp_count);
    chk(ncap == exp_count && addr_err == 0, {req, " R5 writes"}, ncap, exp_count);
    for (int i = 0; i < exp_count && i < ncap; i++)
      chk(cap[i] == pkt[i], {req, " R5 byte"}, int'(cap[i]), int'(pkt[i]));
    chk(!busy, {req, " R1 idle after"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !wr_en && !done && !err_overflow && !err_sync, "R1 reset outputs",
        int'({busy, wr_en, done, err_overflow, err_sync}), 0);
    pkt = '{8'h12, 8'h34};
    build(1'b0, 0, -1);
    clear_obs();
    send();
    chk(ncap == 0 && ndone == 0 && !busy, "R1 unarmed line ignored", ncap + ndone, 0);
  endtask

  task automatic t_basic;
    pkt = '{8'hA5, 8'h3C};
    build(1'b0, 0, -1); arm_and_send();
    check_packet("R3 basic", 2);
  endtask

  task automatic t_zeros;
    pkt = '{8'h00, 8'h00, 8'h81};
    build(1'b0, 0, -1); arm_and_send();
    check_packet("R3 zeros", 3);
  endtask

  task automatic t_stuff;
    pkt = '{8'hFF, 8'hFF, 8'h7E, 8'h80, 8'h3F};
    build(1'b0, 0, -1); arm_and_send();
    check_packet("R4 stuffing", 5);
  endtask

  task automatic t_noise;
    pkt = '{8'hC3, 8'h5A};
    build(1'b1, 0, -1); arm_and_send();
    check_packet("R2 single K retry", 2);
  endtask

  task automatic t_dribble;
    pkt = '{8'h5A};
    build(1'b0, 1, -1); arm_and_send();
    check_packet("R6 partial 1 bit", 1);
    build(1'b0, 7, -1); arm_and_send();
    check_packet("R6 partial 7 bits", 1);
  endtask

  task automatic t_slot0;
    pkt = '{8'h00, 8'h01, 8'h00};
    build(1'b0, 0, 1); arm_and_send();
    check_packet("R7 SE0 in slot 0", 3);
  endtask

  task automatic t_overflow;
    pkt.delete();
    for (int i = 0; i <= DEPTH; i++) pkt.push_back(8'(i * 37 + 5));
    build(1'b0, 0, -1); arm_and_send();
    chk(nov == 1, "R8 overflow pulse", nov, 1);
    chk(ndone == 0, "R8 no done after overflow", ndone, 0);
    chk(ncap == DEPTH && addr_err == 0, "R8 writes stop at depth", ncap, DEPTH);
    chk(cap[DEPTH-1] == pkt[DEPTH-1], "R5 last fitting byte",
        int'(cap[DEPTH-1]), int'(pkt[DEPTH-1]));
    chk(!busy, "R8 idle after overflow", int'(busy), 0);
  endtask

  task automatic t_timeout;
    int cyc;
    clear_obs();
    {dp, dm} = LJ;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (nsync == 0 && cyc < TMO + 50) begin
      @(negedge clk); cyc++;
    end
    chk(nsync == 1, "R9 sync error pulse", nsync, 1);
    chk(cyc >= TMO - 2 && cyc <= TMO + 4, "R9 timeout cycles", cyc, TMO);
    repeat (4) @(negedge clk);
    chk(!busy && ndone == 0 && nov == 0 && nsync == 1, "R10 single outcome",
        ndone + nov + nsync, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    clear_obs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_zeros();
    t_stuff();
    t_noise();
    t_dribble();
    t_slot0();
    t_overflow();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule